// File: doc/BRIEF.md
# USB OTG Interrupt Aggregator with End-of-Interrupt Rearm

This block sits between a USB OTG controller core and the CPU. It gathers one-cycle event pulses from the core into two 32-bit source words. The endpoint word holds transmit and receive endpoint events. The core word holds nine core events, one of which is a VBUS-drive change. Each word has its own enable mask. Software reaches both words, and their masks, through plain, set, clear and masked-view addresses on a simple 32-bit word register port.

A single interrupt line goes to the CPU. A three-state machine (ST_ARMED, ST_RAISED, ST_SPENT) governs it, and the machine re-arms only when software writes the end-of-interrupt address.

- ST_ARMED → ST_RAISED when any masked event is pending (the "fire" transition).
- ST_RAISED → ST_SPENT when software has cleared every pending masked event (the "drain" transition).
- ST_RAISED or ST_SPENT → ST_ARMED on an end-of-interrupt write (the "rearm" transition). An end-of-interrupt write takes priority over drain.

The block also provides:
- a revision word;
- a control word whose bit 0 issues a one-cycle soft-reset pulse to the core;
- a status word that mirrors the VBUS-drive input after synchronisation.

Top module: `usb_irq_wrap`

## Requirements
- R1: After reset, all source and mask bits read 0, the interrupt line and the soft-reset output are low, and the machine is in ST_ARMED.
- R2: Word address 0x00 reads the fixed nonzero value 0x0001_0203. Control (0x04) and every unmapped address (for example 0x10 and 0x5C) read 0.
- R3: Endpoint word packing: transmit endpoint i (0..15) sets bit i, and receive endpoint n (1..15, input bit n-1) sets bit 16+n. Bit 16 always reads 0 and cannot be set.
- R4: Core word packing: core event i (0..8) sets bit 16+i. Bits 15:0 and 31:25 always read 0 and cannot be set.
- R5: Word offsets inside a group, with the endpoint group based at 0x20 and the core group at 0x40:
  - +0x00: source (read-only)
  - +0x04: source set
  - +0x08: source clear
  - +0x0C: mask (read-only)
  - +0x10: mask set
  - +0x14: mask clear

  One bits written to a set or clear address act on the matching bits, and zero bits have no effect. Set and clear addresses read back the current source or mask value.
- R6: Group offset +0x18 reads the source AND the mask.
- R7: When a hardware event and a software clear hit the same source bit in the same cycle, the bit ends up set.
- R8: In ST_ARMED, a masked event captured at clock edge k raises the interrupt line after edge k+1.
- R9: The line stays high until pending masked events are all cleared (drain to ST_SPENT). In ST_SPENT, new events do not raise the line.
- R10: A write of any value to 0x60 rearms the machine. If masked events are still pending, the line goes low for one cycle and then returns high.
- R11: Writing 1 to bit 0 of control raises the soft-reset output for exactly the cycle after the write. Writing 0 produces no pulse.
- R12: Status bit 0 equals the VBUS-drive input delayed by a two-flop synchroniser. Each rising and each falling edge of that input sets core word bit 24 one cycle after status changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| tx_ep_evt | input | 16 | Transmit endpoint event pulses, endpoints 0..15 |
| rx_ep_evt | input | 15 | Receive endpoint event pulses, endpoints 1..15 |
| core_evt | input | 9 | Core event pulses |
| vbus_drv_in | input | 1 | Asynchronous VBUS-drive level |
| irq_o | output | 1 | Interrupt request to the CPU |
| core_soft_rst_o | output | 1 | One-cycle soft-reset pulse to the core |

## Verification
The hardest condition to reach is a pending masked event that arrives while the machine sits in ST_SPENT. That state exists only after the line has fired and software has drained every source.

The stimulus gets there in four steps:
1. Raise the line with an endpoint pulse.
2. Clear that bit through the clear address, so the machine drains to ST_SPENT.
3. Pulse the same endpoint again, and confirm that the masked view shows it while the line stays low.
4. Write end-of-interrupt, and watch the line return one cycle after rearm. A second end-of-interrupt write is then issued while the event is still pending, to exercise the one-cycle drop.

The same-cycle collision of a hardware pulse with a software clear is driven by lining both up on one negative clock edge.

// File: rtl/irqw_pkg.sv
package irqw_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 8;
    localparam int WIDX_W = ADDR_W - 2;

    // word indices (byte address >> 2)
    localparam logic [WIDX_W-1:0] WI_REV  = 6'd0;
    localparam logic [WIDX_W-1:0] WI_CTRL = 6'd1;
    localparam logic [WIDX_W-1:0] WI_STAT = 6'd2;
    localparam logic [WIDX_W-1:0] WI_EOI  = 6'd24;

    // sub-offsets inside a group of seven words
    localparam logic [2:0] SUB_SRC     = 3'd0;
    localparam logic [2:0] SUB_SRC_SET = 3'd1;
    localparam logic [2:0] SUB_SRC_CLR = 3'd2;
    localparam logic [2:0] SUB_MSK     = 3'd3;
    localparam logic [2:0] SUB_MSK_SET = 3'd4;
    localparam logic [2:0] SUB_MSK_CLR = 3'd5;
    localparam logic [2:0] SUB_MASKED  = 3'd6;

    localparam int RX_LSB     = 17;  // receive endpoint n lands on bit 16+n
    localparam int CORE_LSB   = 16;
    localparam int VBUS_EVT   = 8;   // index within the core event field

    typedef enum logic [1:0] {
        ST_ARMED  = 2'd0,
        ST_RAISED = 2'd1,
        ST_SPENT  = 2'd2
    } arm_state_e;

endpackage

// File: rtl/irqw_sync_edge.sv
module irqw_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_o,
    output logic edge_o
);
    // STAGES synchroniser flops plus one history flop
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_in;
    end

    for (genvar s = 1; s <= STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign edge_o  = chain_q[STAGES-1] ^ chain_q[STAGES];
endmodule

// File: rtl/irqw_src_bank.sv
module irqw_src_bank #(
    parameter int           W     = 32,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] src_set,
    input  logic [W-1:0] src_clr,
    input  logic [W-1:0] msk_set,
    input  logic [W-1:0] msk_clr,
    output logic [W-1:0] src_q,
    output logic [W-1:0] msk_q,
    output logic [W-1:0] masked_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            msk_q <= '0;
        end else begin
            // hardware set is OR-ed after the clear so an event is never lost
            src_q <= ((src_q & ~src_clr) | src_set | hw_set) & VALID;
            msk_q <= ((msk_q & ~msk_clr) | msk_set) & VALID;
        end
    end

    assign masked_o = src_q & msk_q;
endmodule

// File: rtl/irqw_arm_fsm.sv
module irqw_arm_fsm
    import irqw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pending,
    input  logic       eoi,
    output logic       irq_o,
    output arm_state_e state_o
);
    arm_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:  if (pending) state_d = ST_RAISED;
            ST_RAISED: begin
                if (eoi)           state_d = ST_ARMED;
                else if (!pending) state_d = ST_SPENT;
            end
            ST_SPENT:  if (eoi) state_d = ST_ARMED;
            default:   state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o   = (state_q == ST_RAISED);
        state_o = state_q;
    end
endmodule

// File: rtl/usb_irq_wrap.sv
module usb_irq_wrap
    import irqw_pkg::*;
#(
    parameter int          N_TX      = 16,
    parameter int          N_RX      = 15,
    parameter int          N_CORE    = 9,
    parameter int          SYNC_STG  = 2,
    parameter logic [31:0] REVISION  = 32'h0001_0203
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [N_TX-1:0]   tx_ep_evt,
    input  logic [N_RX-1:0]   rx_ep_evt,
    input  logic [N_CORE-1:0] core_evt,
    input  logic              vbus_drv_in,
    output logic              irq_o,
    output logic              core_soft_rst_o
);
    localparam int          N_GRP      = 2;
    localparam logic [31:0] EP_VALID   = ((32'h1 << N_TX) - 32'h1)
                                       | (((32'h1 << N_RX) - 32'h1) << RX_LSB);
    localparam logic [31:0] CORE_VALID = ((32'h1 << N_CORE) - 32'h1) << CORE_LSB;

    logic [WIDX_W-1:0] widx;
    logic [1:0]        unused_addr_lo;
    assign widx           = bus_addr[ADDR_W-1:2];
    assign unused_addr_lo = bus_addr[1:0];

    logic wr_en, rd_en;
    assign wr_en = bus_sel &&  bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    // ---------------- VBUS synchroniser ----------------
    logic vbus_lvl, vbus_edge;
    irqw_sync_edge #(.STAGES(SYNC_STG)) u_vbus (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (vbus_drv_in),
        .level_o  (vbus_lvl),
        .edge_o   (vbus_edge)
    );

    // ---------------- event packing ----------------
    logic [N_CORE-1:0] core_evt_all;
    logic [31:0]       hw_vec [N_GRP];
    always_comb begin
        core_evt_all           = core_evt;
        core_evt_all[VBUS_EVT] = core_evt[VBUS_EVT] | vbus_edge;
        hw_vec[0] = 32'(tx_ep_evt) | (32'(rx_ep_evt) << RX_LSB);
        hw_vec[1] = 32'(core_evt_all) << CORE_LSB;
    end

    // ---------------- source / mask groups ----------------
    logic [31:0] src_q  [N_GRP];
    logic [31:0] msk_q  [N_GRP];
    logic [31:0] masked [N_GRP];

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        logic        hit;
        logic [31:0] s_set, s_clr, m_set, m_clr;
        assign hit   = wr_en && (widx[5:3] == 3'(g + 1));
        assign s_set = (hit && widx[2:0] == SUB_SRC_SET) ? bus_wdata : '0;
        assign s_clr = (hit && widx[2:0] == SUB_SRC_CLR) ? bus_wdata : '0;
        assign m_set = (hit && widx[2:0] == SUB_MSK_SET) ? bus_wdata : '0;
        assign m_clr = (hit && widx[2:0] == SUB_MSK_CLR) ? bus_wdata : '0;

        irqw_src_bank #(
            .W     (32),
            .VALID ((g == 0) ? EP_VALID : CORE_VALID)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .hw_set   (hw_vec[g]),
            .src_set  (s_set),
            .src_clr  (s_clr),
            .msk_set  (m_set),
            .msk_clr  (m_clr),
            .src_q    (src_q[g]),
            .msk_q    (msk_q[g]),
            .masked_o (masked[g])
        );
    end

    // ---------------- interrupt arm machine ----------------
    logic       pending, eoi_wr;
    arm_state_e fsm_state;
    assign pending = |(masked[0] | masked[1]);
    assign eoi_wr  = wr_en && (widx == WI_EOI);

    irqw_arm_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .eoi     (eoi_wr),
        .irq_o   (irq_o),
        .state_o (fsm_state)
    );

    // ---------------- soft reset pulse ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) core_soft_rst_o <= 1'b0;
        else        core_soft_rst_o <= wr_en && (widx == WI_CTRL) && bus_wdata[0];
    end

    // ---------------- read mux ----------------
    logic grp_i;
    assign grp_i = widx[4];

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (widx[5:3])
                3'd0: begin
                    if (widx == WI_REV)       bus_rdata = REVISION;
                    else if (widx == WI_STAT) bus_rdata = {31'b0, vbus_lvl};
                end
                3'd1, 3'd2: begin
                    case (widx[2:0])
                        SUB_SRC, SUB_SRC_SET, SUB_SRC_CLR: bus_rdata = src_q[grp_i];
                        SUB_MSK, SUB_MSK_SET, SUB_MSK_CLR: bus_rdata = msk_q[grp_i];
                        SUB_MASKED:                        bus_rdata = masked[grp_i];
                        default:                           bus_rdata = '0;
                    endcase
                end
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/usb_irq_wrap_chk.sv
module usb_irq_wrap_chk
    import irqw_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic        wdata_b0,
    input logic [31:0] bus_rdata,
    input logic        irq_o,
    input logic        core_soft_rst_o,
    input logic [31:0] ep_src,
    input logic [31:0] ep_msk,
    input logic [31:0] ep_hw,
    input logic        pending,
    input logic        eoi_wr,
    input arm_state_e  fsm_state
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R7: a hardware pulse always lands in the source word
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((ep_src & $past(ep_hw)) == $past(ep_hw)));

    // R6: masked view of the endpoint group
    p_masked_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr[7:2] == 6'd14) |-> (bus_rdata == (ep_src & ep_msk)));

    // R8: the line only rises after something was pending
    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(pending));

    // R9: no re-raise while spent without an EOI
    p_no_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_SPENT && !eoi_wr) |=> !irq_o);

    // R10: EOI while raised drops the line for a cycle
    p_eoi_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_RAISED && eoi_wr) |=> !irq_o);

    // R11: soft reset pulse only follows a control write of bit 0
    p_soft_rst_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        core_soft_rst_o |-> $past(bus_sel && bus_wr && bus_addr[7:2] == 6'd1 && wdata_b0));
endmodule

bind usb_irq_wrap usb_irq_wrap_chk chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_sel         (bus_sel),
    .bus_wr          (bus_wr),
    .bus_addr        (bus_addr),
    .wdata_b0        (bus_wdata[0]),
    .bus_rdata       (bus_rdata),
    .irq_o           (irq_o),
    .core_soft_rst_o (core_soft_rst_o),
    .ep_src          (src_q[0]),
    .ep_msk          (msk_q[0]),
    .ep_hw           (hw_vec[0]),
    .pending         (pending),
    .eoi_wr          (eoi_wr),
    .fsm_state       (fsm_state)
);

// File: tb/usb_irq_wrap_tb.sv
module usb_irq_wrap_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] tx_ep_evt = '0;
    logic [14:0] rx_ep_evt = '0;
    logic [8:0]  core_evt = '0;
    logic        vbus_drv_in = 1'b0;
    logic        irq_o, core_soft_rst_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    usb_irq_wrap dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_ep_evt(tx_ep_evt), .rx_ep_evt(rx_ep_evt), .core_evt(core_evt),
        .vbus_drv_in(vbus_drv_in), .irq_o(irq_o), .core_soft_rst_o(core_soft_rst_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // {is_write, addr, data, expected}
    localparam int NV = 17;
    localparam logic [72:0] VEC [NV] = '{
        {1'b0, 8'h00, 32'h0,          32'h0001_0203},  // R2 revision
        {1'b1, 8'h30, 32'hFFFF_FFFF,  32'h0},          // R5 mask set
        {1'b0, 8'h2C, 32'h0,          32'hFFFE_FFFF},  // R3 bit 16 absent
        {1'b1, 8'h34, 32'h0000_00FF,  32'h0},          // R5 mask clear
        {1'b0, 8'h30, 32'h0,          32'hFFFE_FF00},  // R5 alias read
        {1'b1, 8'h24, 32'h0001_0101,  32'h0},          // R5 source set
        {1'b0, 8'h20, 32'h0,          32'h0000_0101},  // R3 bit 16 dropped
        {1'b0, 8'h38, 32'h0,          32'h0000_0100},  // R6 masked view
        {1'b1, 8'h28, 32'h0000_0100,  32'h0},          // R5 source clear
        {1'b0, 8'h28, 32'h0,          32'h0000_0001},  // R5 zero bits untouched
        {1'b1, 8'h50, 32'hFFFF_FFFF,  32'h0},          // R4 core mask set
        {1'b0, 8'h4C, 32'h0,          32'h01FF_0000},  // R4 field only
        {1'b1, 8'h44, 32'h0200_0001,  32'h0},          // R4 outside field
        {1'b0, 8'h40, 32'h0,          32'h0},          // R4 nothing set
        {1'b1, 8'h20, 32'hFFFF_FFFF,  32'h0},          // R5 raw read-only
        {1'b0, 8'h20, 32'h0,          32'h0000_0001},  // R5
        {1'b0, 8'h5C, 32'h0,          32'h0}           // R2 unmapped
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        // R1 reset state
        @(negedge clk);
        check("R1 irq", 32'(irq_o), 32'h0);
        check("R1 soft_rst", 32'(core_soft_rst_o), 32'h0);
        bus_read("R1 ep src", 8'h20, 32'h0);
        bus_read("R1 core mask", 8'h4C, 32'h0);
        bus_read("R2 ctrl", 8'h04, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) bus_write(VEC[i][71:64], VEC[i][63:32]);
            else            bus_read("R2-R6 table", VEC[i][71:64], VEC[i][31:0]);
        end

        // interrupt machine
        do_reset();
        bus_write(8'h30, 32'h0000_0008);
        @(negedge clk); tx_ep_evt[3] = 1'b1;
        @(negedge clk); tx_ep_evt = '0;
        check("R8 not yet", 32'(irq_o), 32'h0);
        @(negedge clk);
        check("R8 raised", 32'(irq_o), 32'h1);
        bus_write(8'h28, 32'h0000_0008);
        check("R9 still high", 32'(irq_o), 32'h1);
        @(negedge clk);
        check("R9 drained", 32'(irq_o), 32'h0);
        @(negedge clk); tx_ep_evt[3] = 1'b1;
        @(negedge clk); tx_ep_evt = '0;
        @(negedge clk);
        check("R9 spent no raise", 32'(irq_o), 32'h0);
        bus_read("R9 pending", 8'h38, 32'h0000_0008);
        bus_write(8'h60, 32'h1234_5678);
        check("R10 rearm low", 32'(irq_o), 32'h0);
        @(negedge clk);
        check("R10 rearm raise", 32'(irq_o), 32'h1);
        bus_write(8'h60, 32'h0);
        check("R10 drop", 32'(irq_o), 32'h0);
        @(negedge clk);
        check("R10 return", 32'(irq_o), 32'h1);

        // R7 set beats clear
        bus_write(8'h24, 32'h0000_0020);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h28; bus_wdata = 32'h0000_0020;
        tx_ep_evt[5] = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tx_ep_evt = '0;
        bus_read("R7 set wins", 8'h20, 32'h0000_0028);

        // R3 receive endpoint 1 -> bit 17
        @(negedge clk); rx_ep_evt = 15'h0001;
        @(negedge clk); rx_ep_evt = '0;
        bus_read("R3 rx ep1", 8'h20, 32'h0002_0028);

        // R11 soft reset
        bus_write(8'h04, 32'h1);
        check("R11 pulse", 32'(core_soft_rst_o), 32'h1);
        @(negedge clk);
        check("R11 one cycle", 32'(core_soft_rst_o), 32'h0);
        bus_write(8'h04, 32'h0);
        check("R11 zero write", 32'(core_soft_rst_o), 32'h0);

        // R12 vbus
        @(negedge clk); vbus_drv_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_read("R12 status sync", 8'h08, 32'h1);
        bus_read("R12 rise event", 8'h40, 32'h0100_0000);
        bus_write(8'h48, 32'h0100_0000);
        vbus_drv_in = 1'b0;
        repeat (3) @(negedge clk);
        bus_read("R12 fall event", 8'h40, 32'h0100_0000);
        bus_read("R12 status low", 8'h08, 32'h0);

        // R4 core events
        @(negedge clk); core_evt = 9'h005;
        @(negedge clk); core_evt = '0;
        bus_read("R4 core pack", 8'h40, 32'h0105_0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule